// File: doc/BRIEF.md
# Serial Page-Write Memory Slave

This block is the write path of a serial byte memory seen from the bus side. A host selects it with an active-low select line and clocks in a frame MSB first: a command byte, two address bytes and one or more data bytes. If the command is the page-write opcode, the data bytes go into a page-sized staging buffer. The host then releases select. If the frame ended on a whole byte and the write is permitted, a timed write cycle begins. During that cycle, every staged byte is copied into the byte array in one pass.

Four things gate a write: a write-enable latch, a busy flag, a two-bit protection field and the byte alignment of the deselect. The enable latch drops after every write cycle and after every refused write frame. The serial inputs are asynchronous to the system clock, and the block oversamples them. Test-side ports can set the enable latch, load the protection field and read any array byte combinationally.

Top module: `spi_page_writer`

## Requirements
- R1: After reset, `wel` and `wip` are 0. `sdo_en` is 0 on every cycle, so the serial output is never driven.
- R2: The serial format is mode 0 (`mosi` sampled on the rising `sck` edge), MSB first, while `cs_n` is low. The frame is opcode 0x02, a 16-bit address, then data. Only the low `ADDR_W` address bits are used; bit 15 and every other bit above them are ignored.
- R3: A write is committed only if `cs_n` rises after a whole number of bytes and at least one data byte arrived. A rise mid-byte, or before any data byte, discards the whole frame and leaves the array unchanged.
- R4: Each data byte advances only the low `PAGE_W` address bits. Past the last byte of the page, the address wraps to the first byte of the same page, and a later byte overwrites an earlier one for the same position.
- R5: Only the byte positions received in the frame are written. Every other byte of the page keeps its previous contents.
- R6: On an accepted write, `wip` goes to 1 on the third system clock edge after `cs_n` goes high and stays 1 for exactly `TWC_CYC` cycles. The array holds the new bytes once `wip` is 0 again.
- R7: A write frame is refused if `wel` was 0.
- R8: A write frame that ends while `wip` is 1 is refused, and the write cycle already running is not disturbed.
- R9: A write frame is refused if its address lies in the protected region. The protection codes are: 00 none, 01 the top quarter of the array, 10 the top half, 11 the whole array.
- R10: `wel` goes to 0 when a write cycle ends. It also goes to 0, on the same edge at which an accepted write would raise `wip`, when a frame that carried the write opcode is refused. A frame with any other opcode leaves `wel` unchanged.
- R11: A pulse on `tst_wel_set` sets `wel` on the next clock edge. `tst_bp_load` loads `tst_bp` into the protection field on the next clock edge. `peek_data` shows the array byte at `peek_addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| sdo_en | output | 1 | Serial output enable, always 0 |
| tst_wel_set | input | 1 | Test hook: set the write-enable latch |
| tst_bp_load | input | 1 | Test hook: load the protection field |
| tst_bp | input | 2 | Test hook: protection code to load |
| peek_addr | input | ADDR_W | Test hook: array byte address to read |
| peek_data | output | 8 | Array byte at `peek_addr` |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle in progress |

## Verification
The assertions watch the control state on every cycle:
- a write cycle starts only with the latch set, in an unprotected page and at a byte-aligned deselect;
- the timer counts down one step per cycle;
- the target page cannot change during a cycle;
- the latch is clear when a cycle ends.

The frame-level behaviours can only be shown by the bench's scenarios, because they depend on what ends up in the array:
- page wrap with overwrite;
- untouched neighbour bytes;
- address-bit masking;
- refused frames leaving memory intact.

The bench's reference model predicts `wel` and `wip` cycle by cycle from the frames it sends.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_OPC,
        CS_AHI,
        CS_ALO,
        CS_DATA,
        CS_SKIP
    } cmd_state_e;

    localparam logic [7:0] OPC_PAGE_WRITE = 8'h02;

    localparam logic [1:0] LOCK_NONE    = 2'b00;
    localparam logic [1:0] LOCK_QUARTER = 2'b01;
    localparam logic [1:0] LOCK_HALF    = 2'b10;

    // top2 holds the two most significant bits of the byte address
    function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
        logic hit;
        case (bp)
            LOCK_NONE:    hit = 1'b0;
            LOCK_QUARTER: hit = (top2 == 2'b11);
            LOCK_HALF:    hit = top2[1];
            default:      hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spiw_rx.sv
module spiw_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       cs_fall_o,
    output logic       cs_rise_o,
    output logic       aligned_o,
    output logic       byte_stb_o,
    output logic [7:0] byte_o
);

    typedef struct packed {
        logic [1:0] cs_p;
        logic [1:0] ck_p;
        logic [1:0] d_p;
        logic       cs_l;
        logic       ck_l;
        logic [2:0] cnt;
        logic [6:0] sh;
    } rx_t;

    rx_t  r_q, r_d;
    logic ck_rise;

    always_comb begin
        r_d      = r_q;
        r_d.cs_p = {r_q.cs_p[0], cs_n};
        r_d.ck_p = {r_q.ck_p[0], sck};
        r_d.d_p  = {r_q.d_p[0], mosi};
        r_d.cs_l = r_q.cs_p[1];
        r_d.ck_l = r_q.ck_p[1];

        ck_rise    = r_q.ck_p[1] & ~r_q.ck_l;
        cs_fall_o  = ~r_q.cs_p[1] & r_q.cs_l;
        cs_rise_o  = r_q.cs_p[1] & ~r_q.cs_l;
        aligned_o  = (r_q.cnt == 3'd0);
        byte_o     = {r_q.sh, r_q.d_p[1]};
        byte_stb_o = 1'b0;

        if (cs_fall_o) begin
            r_d.cnt = '0;
        end else if (ck_rise && !r_q.cs_p[1]) begin
            r_d.sh     = {r_q.sh[5:0], r_q.d_p[1]};
            r_d.cnt    = r_q.cnt + 3'd1;
            byte_stb_o = (r_q.cnt == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cs_p: 2'b11, ck_p: 2'b00, d_p: 2'b00, cs_l: 1'b1,
                     ck_l: 1'b0, cnt: 3'd0, sh: 7'd0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spiw_ctrl.sv
module spiw_ctrl
    import spiw_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAGE_W  = 6,
    parameter int TWC_CYC = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_fall,
    input  logic                     cs_rise,
    input  logic                     aligned,
    input  logic                     byte_stb,
    input  logic [7:0]               byte_v,
    input  logic                     wel_set,
    input  logic                     bp_load,
    input  logic [1:0]               bp_in,
    output logic                     wel_o,
    output logic                     wip_o,
    output logic                     fill_we,
    output logic [PAGE_W-1:0]        fill_idx,
    output logic [7:0]               fill_byte,
    output logic                     buf_clr,
    output logic                     copy_en,
    output logic [PAGE_W-1:0]        copy_idx,
    output logic [ADDR_W-PAGE_W-1:0] copy_page
);

    localparam int PG_W = ADDR_W - PAGE_W;
    localparam int HI_W = ADDR_W - 8;
    localparam int TW   = $clog2(TWC_CYC);

    typedef struct packed {
        cmd_state_e        st;
        logic [HI_W-1:0]   ahi;
        logic [PG_W-1:0]   cpage;
        logic [PAGE_W-1:0] off;
        logic              got;
        logic              wel;
        logic              wip;
        logic [TW-1:0]     tmr;
        logic              copying;
        logic [PAGE_W-1:0] cidx;
        logic [PG_W-1:0]   wpage;
        logic [1:0]        bp;
    } ctl_t;

    ctl_t c_q, c_d;
    logic ok;

    always_comb begin
        c_d       = c_q;
        fill_we   = 1'b0;
        buf_clr   = 1'b0;
        ok        = 1'b0;
        fill_idx  = c_q.off;
        fill_byte = byte_v;

        if (bp_load) c_d.bp  = bp_in;
        if (wel_set) c_d.wel = 1'b1;

        // copy pass over the staged page, one position per cycle
        if (c_q.copying) begin
            c_d.cidx = c_q.cidx + 1'b1;
            if (c_q.cidx == '1) begin
                c_d.copying = 1'b0;
                buf_clr     = 1'b1;
            end
        end

        // self-timed cycle
        if (c_q.wip) begin
            if (c_q.tmr == '0) begin
                c_d.wip = 1'b0;
                c_d.wel = 1'b0;
            end else begin
                c_d.tmr = c_q.tmr - 1'b1;
            end
        end

        if (cs_fall) begin
            c_d.st  = CS_OPC;
            c_d.got = 1'b0;
            c_d.off = '0;
            if (!c_q.wip) buf_clr = 1'b1;
        end else if (byte_stb) begin
            case (c_q.st)
                CS_OPC: c_d.st = (byte_v == OPC_PAGE_WRITE) ? CS_AHI : CS_SKIP;
                CS_AHI: begin
                    c_d.ahi = byte_v[HI_W-1:0];
                    c_d.st  = CS_ALO;
                end
                CS_ALO: begin
                    c_d.cpage = {c_q.ahi, byte_v[7:PAGE_W]};
                    c_d.off   = byte_v[PAGE_W-1:0];
                    c_d.st    = CS_DATA;
                end
                CS_DATA: begin
                    c_d.got = 1'b1;
                    c_d.off = c_q.off + 1'b1;
                    fill_we = !c_q.wip;
                end
                default: ;
            endcase
        end else if (cs_rise) begin
            c_d.st = CS_IDLE;
            if (c_q.st inside {CS_AHI, CS_ALO, CS_DATA}) begin
                ok = (c_q.st == CS_DATA) && c_q.got && aligned && c_q.wel && !c_q.wip
                     && !region_locked(c_q.bp, c_q.cpage[PG_W-1 -: 2]);
                if (ok) begin
                    c_d.wip     = 1'b1;
                    c_d.tmr     = TW'(TWC_CYC - 1);
                    c_d.copying = 1'b1;
                    c_d.cidx    = '0;
                    c_d.wpage   = c_q.cpage;
                end else begin
                    c_d.wel = 1'b0;
                    if (!c_q.copying) buf_clr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign wel_o     = c_q.wel;
    assign wip_o     = c_q.wip;
    assign copy_en   = c_q.copying;
    assign copy_idx  = c_q.cidx;
    assign copy_page = c_q.wpage;

    p_start_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.wip) |-> $past(c_q.wel));

    p_start_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.wip) |-> $past(aligned) && $past(cs_rise));

    p_start_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.wip) |-> !region_locked($past(c_q.bp), c_q.wpage[PG_W-1 -: 2]));

    p_page_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.wip && $past(c_q.wip) |-> $stable(c_q.wpage));

    p_timer_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.wip && $past(c_q.wip) |-> (c_q.tmr + 1'b1) == $past(c_q.tmr));

    p_wel_off_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.wip) |-> !c_q.wel);

endmodule

// File: rtl/spiw_store.sv
module spiw_store #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_we,
    input  logic [PAGE_W-1:0]        fill_idx,
    input  logic [7:0]               fill_byte,
    input  logic                     buf_clr,
    input  logic                     copy_en,
    input  logic [PAGE_W-1:0]        copy_idx,
    input  logic [ADDR_W-PAGE_W-1:0] copy_page,
    input  logic [ADDR_W-1:0]        peek_addr,
    output logic [7:0]               peek_data
);

    localparam int PAGE_N = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [7:0]        pbuf [PAGE_N];
    logic [7:0]        mem  [DEPTH];
    logic [PAGE_N-1:0] dirty_q, dirty_d;

    always_comb begin
        dirty_d = dirty_q;
        if (buf_clr) dirty_d = '0;
        if (fill_we) dirty_d[fill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dirty_q <= '0;
        else        dirty_q <= dirty_d;
    end

    always_ff @(posedge clk) begin
        if (fill_we) pbuf[fill_idx] <= fill_byte;
    end

    always_ff @(posedge clk) begin
        if (copy_en && dirty_q[copy_idx]) mem[{copy_page, copy_idx}] <= pbuf[copy_idx];
    end

    assign peek_data = mem[peek_addr];

    p_fill_outside_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !copy_en);

endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
    parameter int ADDR_W  = 10,
    parameter int PAGE_W  = 6,
    parameter int TWC_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              sdo_en,
    input  logic              tst_wel_set,
    input  logic              tst_bp_load,
    input  logic [1:0]        tst_bp,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    output logic              wel,
    output logic              wip
);

    localparam int PG_W = ADDR_W - PAGE_W;

    logic              cs_fall, cs_rise, aligned, byte_stb;
    logic [7:0]        byte_v;
    logic              fill_we, buf_clr, copy_en;
    logic [PAGE_W-1:0] fill_idx, copy_idx;
    logic [7:0]        fill_byte;
    logic [PG_W-1:0]   copy_page;

    spiw_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .cs_fall_o  (cs_fall),
        .cs_rise_o  (cs_rise),
        .aligned_o  (aligned),
        .byte_stb_o (byte_stb),
        .byte_o     (byte_v)
    );

    spiw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWC_CYC(TWC_CYC)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .aligned   (aligned),
        .byte_stb  (byte_stb),
        .byte_v    (byte_v),
        .wel_set   (tst_wel_set),
        .bp_load   (tst_bp_load),
        .bp_in     (tst_bp),
        .wel_o     (wel),
        .wip_o     (wip),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_byte (fill_byte),
        .buf_clr   (buf_clr),
        .copy_en   (copy_en),
        .copy_idx  (copy_idx),
        .copy_page (copy_page)
    );

    spiw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_byte (fill_byte),
        .buf_clr   (buf_clr),
        .copy_en   (copy_en),
        .copy_idx  (copy_idx),
        .copy_page (copy_page),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    assign sdo_en = 1'b0;

endmodule

// File: tb/sim_spi_page_writer.sv
`timescale 1ns/1ps
module sim_spi_page_writer;

    localparam int AW   = 10;
    localparam int PW   = 6;
    localparam int TWC  = 400;
    localparam int HALF = 3;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic          tst_wel_set = 1'b0, tst_bp_load = 1'b0;
    logic [1:0]    tst_bp = 2'b00;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;
    logic          sdo_en, wel, wip;

    always #2.5 clk = ~clk;

    spi_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .TWC_CYC(TWC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .sdo_en(sdo_en), .tst_wel_set(tst_wel_set), .tst_bp_load(tst_bp_load),
        .tst_bp(tst_bp), .peek_addr(peek_addr), .peek_data(peek_data),
        .wel(wel), .wip(wip)
    );

    int total = 0, bad = 0;

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit         m_wel = 0, m_wip = 0, m_commit = 0, cmp_on = 0;
    int         m_cnt = 0, m_pend = 0;
    logic [1:0] m_bp = 2'b00;
    int         m_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_wip = 0; m_pend = 0; m_bp = 2'b00;
        end else begin
            if (tst_bp_load) m_bp = tst_bp;
            if (tst_wel_set) m_wel = 1;
            if (m_wip) begin
                m_cnt--;
                if (m_cnt == 0) begin m_wip = 0; m_wel = 0; end
            end
            if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    if (m_commit) begin m_wip = 1; m_cnt = TWC; end
                    else m_wel = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R6 R8 wip", int'(wip), int'(m_wip));
            check("R7 R10 wel", int'(wel), int'(m_wel));
            check("R1 sdo_en", int'(sdo_en), 0);
        end
    end

    function automatic bit locked(input logic [1:0] bp, input int a);
        int sz = 1 << AW;
        case (bp)
            2'b00:   return 0;
            2'b01:   return a >= (sz * 3) / 4;
            2'b10:   return a >= sz / 2;
            default: return 1;
        endcase
    endfunction

    // ---------------- serial driver ----------------
    int         t_bits;
    logic [7:0] t_bytes [$];

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input bit b);
        mosi = b; cyc(HALF);
        sck = 1'b1; cyc(HALF);
        sck = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, input int n);
        for (int i = 7; i >= 8 - n; i--) put_bit(v[i]);
        t_bits += n;
        if (n == 8) t_bytes.push_back(v);
    endtask

    task automatic cs_low();
        cyc(1);
        cs_n = 1'b0;
        t_bits = 0;
        t_bytes.delete();
        cyc(4);
    endtask

    task automatic decide();
        int  a, base, off;
        bit  good;
        if (t_bits < 8 || t_bytes[0] != 8'h02) return;
        good = 0;
        if (t_bytes.size() >= 4 && (t_bits % 8) == 0) begin
            a    = ((int'(t_bytes[1]) << 8) | int'(t_bytes[2])) & ((1 << AW) - 1);
            good = m_wel && !m_wip && !locked(m_bp, a);
            if (good) begin
                base = a & ~((1 << PW) - 1);
                off  = a & ((1 << PW) - 1);
                for (int i = 3; i < t_bytes.size(); i++)
                    m_mem[base + ((off + i - 3) & ((1 << PW) - 1))] = int'(t_bytes[i]);
            end
        end
        m_commit = good;
        m_pend   = 3;
    endtask

    task automatic cs_high();
        cyc(4);
        decide();
        cs_n = 1'b1;
        cyc(6);
    endtask

    task automatic spi_wr(input int a16, input logic [7:0] d [$], input int tail);
        cs_low();
        put_byte(8'h02, 8);
        put_byte(8'(a16 >> 8), 8);
        put_byte(8'(a16), 8);
        foreach (d[i]) put_byte(d[i], 8);
        if (tail > 0) put_byte(8'hA5, tail);
        cs_high();
    endtask

    task automatic set_wel();
        tst_wel_set = 1'b1; cyc(1); tst_wel_set = 1'b0;
    endtask

    task automatic set_bp(input logic [1:0] v);
        tst_bp = v; tst_bp_load = 1'b1; cyc(1); tst_bp_load = 1'b0;
    endtask

    task automatic wait_idle();
        cyc(TWC + 20);
    endtask

    task automatic peek_chk(input int a, input string tag);
        peek_addr = AW'(a);
        #1;
        if (m_mem.exists(a)) check(tag, int'(peek_data), m_mem[a]);
        else check({tag, " model has no byte"}, 1, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [7:0] q [$];
        cyc(3);
        check("R1 reset wel", int'(wel), 0);
        check("R1 reset wip", int'(wip), 0);
        check("R1 reset sdo_en", int'(sdo_en), 0);
        cmp_on = 1;
        rst_n  = 1'b1;
        cyc(3);

        // R2 R6: basic single-byte write
        set_wel();
        q = '{8'h5A};
        spi_wr(16'h0010, q, 0);
        check("R6 wip raised", int'(wip), 1);
        wait_idle();
        peek_chk(16'h0010, "R2 R11 single byte");
        check("R10 wel cleared after cycle", int'(wel), 0);

        // R7: no enable latch
        q = '{8'h66};
        spi_wr(16'h0010, q, 0);
        wait_idle();
        peek_chk(16'h0010, "R7 refused without wel");

        // R2: upper address bits including b15 ignored
        set_wel();
        q = '{8'h77};
        spi_wr(16'h8411, q, 0);
        wait_idle();
        peek_chk(16'h0011, "R2 masked address");
        peek_chk(16'h0010, "R2 neighbour intact");

        // R4: full page
        set_wel();
        q.delete();
        for (int i = 0; i < 64; i++) q.push_back(8'(i * 7 + 3));
        spi_wr(16'h0080, q, 0);
        wait_idle();
        peek_chk(16'h0080, "R4 page first");
        peek_chk(16'h00A5, "R4 page middle");
        peek_chk(16'h00BF, "R4 page last");

        // R4 R5: wrap inside page, partial update
        set_wel();
        q = '{8'hAA, 8'hBB, 8'hCC};
        spi_wr(16'h00BE, q, 0);
        wait_idle();
        peek_chk(16'h00BE, "R4 wrap pre");
        peek_chk(16'h00BF, "R4 wrap end");
        peek_chk(16'h0080, "R4 wrapped byte");
        peek_chk(16'h0081, "R5 untouched after wrap");
        peek_chk(16'h00BD, "R5 untouched before start");

        // R3: deselect mid-byte
        set_wel();
        q = '{8'h12};
        spi_wr(16'h0081, q, 4);
        wait_idle();
        peek_chk(16'h0081, "R3 mid-byte discard");
        check("R3 R10 wel after mid-byte", int'(wel), 0);

        // R3: no data byte
        set_wel();
        q.delete();
        spi_wr(16'h0082, q, 0);
        cyc(10);
        check("R3 R10 wel after empty frame", int'(wel), 0);
        peek_chk(16'h0082, "R3 empty frame no write");

        // R9: protection baselines
        set_bp(2'b00);
        foreach (q[i]) q.delete();
        begin
            int bases [4] = '{16'h0350, 16'h02F0, 16'h0200, 16'h0000};
            foreach (bases[k]) begin
                set_wel();
                q = '{8'(k + 1)};
                spi_wr(bases[k], q, 0);
                wait_idle();
            end
        end
        set_bp(2'b01);
        set_wel(); q = '{8'h21}; spi_wr(16'h0350, q, 0); wait_idle();
        peek_chk(16'h0350, "R9 quarter locked");
        set_wel(); q = '{8'h22}; spi_wr(16'h02F0, q, 0); wait_idle();
        peek_chk(16'h02F0, "R9 quarter below open");
        set_bp(2'b10);
        set_wel(); q = '{8'h23}; spi_wr(16'h0200, q, 0); wait_idle();
        peek_chk(16'h0200, "R9 half locked");
        set_bp(2'b11);
        set_wel(); q = '{8'h24}; spi_wr(16'h0000, q, 0); wait_idle();
        peek_chk(16'h0000, "R9 all locked");
        set_bp(2'b00);

        // R8: frame during a running cycle
        set_wel();
        q = '{8'h31};
        spi_wr(16'h0010, q, 0);
        q = '{8'h32};
        spi_wr(16'h0011, q, 0);
        check("R8 wip still running", int'(wip), 1);
        check("R8 R10 wel dropped", int'(wel), 0);
        wait_idle();
        peek_chk(16'h0010, "R8 first write landed");
        peek_chk(16'h0011, "R8 second write refused");

        // R10: other opcode leaves wel
        set_wel();
        cs_low();
        put_byte(8'h03, 8);
        put_byte(8'h00, 8);
        put_byte(8'h10, 8);
        cs_high();
        cyc(5);
        check("R10 other opcode keeps wel", int'(wel), 1);
        q = '{8'h44};
        spi_wr(16'h0012, q, 0);
        wait_idle();
        peek_chk(16'h0012, "R10 R11 write after other opcode");

        cyc(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule